// File: doc/BRIEF.md
# Bit-Serial CRC Engine with Byte Front End

This block computes a cyclic redundancy check one message bit per clock. It keeps an n-bit remainder register whose leading generator coefficient is implicit. Each incoming bit is XORed with the register's top bit only when that bit decides the feedback. As a result the message needs no trailing zero padding, and the register is never preloaded with message bits. The generator polynomial, the preset value, the output inversion mask and the bit ordering of bytes are all parameters.

Data enters either as single bits or as whole bytes. A byte is serialised over eight clocks, starting with bit 7 or with bit 0 as the ordering parameter selects. The block has three uses. It can generate a CRC to append to a frame. It can recompute a CRC for comparison. It can check a frame in one pass by running over the message followed by its received CRC. In that last use, the final register is compared with a residue constant that the block derives from the polynomial and the inversion mask. The check therefore holds for any preset.

Top module: `crc_serial_unit`

## Requirements
- R1: During reset, and after a `start_i` pulse that comes with no accepted data, the remainder register holds PRESET. `busy_o` and `done_o` are low after reset.
- R2: Each accepted bit d updates the register r as follows: feedback f = r[W-1] xor d, then r becomes (r shifted left by one) xor (POLY if f). After L bits from preset P, the register equals (P·x^L + M·x^W) mod G, where G is x^W plus POLY.
- R3: `crc_o` is the register XOR XOROUT. In MSB order it is presented unchanged. In LSB order it is bit-reversed, so that sending its bytes low byte first, each with bit 0 first, transmits the register's top bit first.
- R4: In MSB order a byte is fed bit 7 first. In LSB order it is fed bit 0 first. With POLY 0x07, zero preset and no inversion, the byte 0x57 in MSB order gives `crc_o` = 0xA2.
- R5: An accepted byte (`byte_valid_i` while `busy_o` is low) raises `busy_o` for exactly eight cycles, one bit per cycle. `byte_valid_i` is ignored while `busy_o` is high.
- R6: `bit_valid_i` is ignored while `busy_o` is high, and in any cycle where `byte_valid_i` is high.
- R7: `done_o` is high for the one cycle that follows the clock edge that consumed the bit marked last. For a byte, that is the byte's eighth bit. `done_o` is never high together with `busy_o`.
- R8: `pass_o` is high when the register equals the residue. The residue is the register obtained by feeding the W bits of XOROUT, top bit first, into a zero register. A message followed by its own appended `crc_o` bytes gives `pass_o` high at `done_o`, whatever the preset.
- R9: Flipping any single bit of a message or of its appended CRC gives `pass_o` low at `done_o`.
- R10: `start_i` aborts a byte in progress. Data accepted in the same cycle as `start_i` is processed from PRESET.
- R11: With no accepted bit and no `start_i`, the register and `crc_o` hold their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads PRESET |
| start_i | input | 1 | Begin a new frame: register to PRESET, abort any byte in progress |
| bit_valid_i | input | 1 | A single message bit is offered on `bit_i` |
| bit_i | input | 1 | Message bit |
| byte_valid_i | input | 1 | A message byte is offered on `byte_i` |
| byte_i | input | 8 | Message byte |
| last_i | input | 1 | Marks the offered bit or byte as the final one of the frame |
| busy_o | output | 1 | Byte serialiser is occupied |
| crc_o | output | CRC_W | Register XOR XOROUT, reflected in LSB order |
| done_o | output | 1 | One-cycle pulse after the last bit is consumed |
| pass_o | output | 1 | Register equals the one-pass residue |

## Verification
The bench sweeps every single-byte message through two configurations: MSB order with no preset or inversion, and LSB order with an all-ones preset and all-ones inversion. It compares each result with a long-division model, and also covers bit-mode frames of lengths 1 to 12 and multi-byte messages. A block that reversed the byte order, skipped reflection on output, or applied the preset as a plain XOR on the output would diverge on almost every byte. A residue taken as zero under inversion would make every one-pass check in the inverted configuration fail.

Every single-bit corruption of a four-byte framed message is replayed in both configurations, to show that the check drops. The bench also drives bits and bytes into a busy serialiser, and aborts a byte midway with `start_i`. A block whose arbitration leaked those inputs would show a wrong CRC, and a wrong busy length or a late `done_o` would show at the sample points.

// File: rtl/crc_pkg.sv
package crc_pkg;

  // Which bit of a byte enters the divider first.
  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/crc_byte_feed.sv
module crc_byte_feed
  import crc_pkg::*;
#(
  parameter bit_order_e ORDER = ORDER_MSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              abort_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  output logic              step_o,
  output logic              bit_o,
  output logic              last_o,
  output logic              busy_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  logic              last_q;
  logic [BYTE_W-1:0] ordered_w;

  // Put the first-to-send bit at the top of the shifter.
  generate
    if (ORDER == ORDER_LSB) begin : g_reflect
      always_comb begin
        for (int i = 0; i < BYTE_W; i++) ordered_w[i] = byte_i[BYTE_W-1-i];
      end
    end else begin : g_direct
      assign ordered_w = byte_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
      last_q  <= 1'b0;
    end else if (load_i) begin
      shreg_q <= ordered_w;
      left_q  <= CNT_W'(BYTE_W);
      last_q  <= last_i;
    end else if (abort_i) begin
      left_q  <= '0;
      last_q  <= 1'b0;
    end else if (left_q != '0) begin
      shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
      left_q  <= left_q - 1'b1;
    end
  end

  assign busy_o = (left_q != '0);
  assign step_o = busy_o;
  assign bit_o  = shreg_q[BYTE_W-1];
  assign last_o = last_q && (left_q == CNT_W'(1));

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o);

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(abort_i)) |-> $past(busy_o, 8));

endmodule

// File: rtl/crc_shift_core.sv
module crc_shift_core
  import crc_pkg::*;
#(
  parameter int               W      = 8,
  parameter logic [W-1:0]     POLY   = 'h07,
  parameter logic [W-1:0]     PRESET = '0,
  parameter logic [W-1:0]     XOROUT = '0,
  parameter bit_order_e       ORDER  = ORDER_MSB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         bit_i,
  input  logic         last_i,
  output logic [W-1:0] crc_o,
  output logic         done_o,
  output logic         pass_o
);

  // One divider step: the message bit joins at the moment it is tested.
  function automatic logic [W-1:0] crc_advance(input logic [W-1:0] r, input logic d);
    logic f;
    f = r[W-1] ^ d;
    return {r[W-2:0], 1'b0} ^ (f ? POLY : '0);
  endfunction

  function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = v[W-1-i];
    return m;
  endfunction

  // Register left by a correct one-pass check: the inversion mask run
  // through a cleared divider.
  function automatic logic [W-1:0] residue_of();
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--) r = crc_advance(r, XOROUT[i]);
    return r;
  endfunction

  localparam logic [W-1:0] RESIDUE = residue_of();

  logic [W-1:0] crc_q;
  logic         done_q;
  logic [W-1:0] base_w;
  logic [W-1:0] next_w;
  logic [W-1:0] masked_w;
  logic         fb_w;

  assign base_w   = start_i ? PRESET : crc_q;
  assign fb_w     = base_w[W-1] ^ bit_i;
  assign next_w   = step_i ? crc_advance(base_w, bit_i) : base_w;
  assign masked_w = crc_q ^ XOROUT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= PRESET;
      done_q <= 1'b0;
    end else begin
      crc_q  <= next_w;
      done_q <= step_i && last_i;
    end
  end

  generate
    if (ORDER == ORDER_LSB) begin : g_out_reflect
      assign crc_o = mirror(masked_w);
    end else begin : g_out_direct
      assign crc_o = masked_w;
    end
  endgenerate

  assign done_o = done_q;
  assign pass_o = (crc_q == RESIDUE);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !step_i) |=> $stable(crc_o));

  // R1
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !step_i) |=> (crc_q == PRESET));

  // R2
  lsb_fb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (crc_q[0] == ($past(fb_w) & POLY[0])));

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
  import crc_pkg::*;
#(
  parameter int                 CRC_W  = 8,
  parameter logic [CRC_W-1:0]   POLY   = 'h07,
  parameter logic [CRC_W-1:0]   PRESET = '0,
  parameter logic [CRC_W-1:0]   XOROUT = '0,
  parameter bit_order_e         ORDER  = ORDER_MSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              last_i,
  output logic              busy_o,
  output logic [CRC_W-1:0]  crc_o,
  output logic              done_o,
  output logic              pass_o
);

  logic ser_busy;
  logic ser_step;
  logic ser_bit;
  logic ser_last;
  logic byte_take;
  logic bit_take;
  logic feed_step;
  logic feed_bit;
  logic feed_last;
  logic ser_live;

  // Bytes win over bits; a busy serialiser blocks both.
  assign byte_take = byte_valid_i && !ser_busy;
  assign bit_take  = bit_valid_i && !ser_busy && !byte_valid_i;
  assign ser_live  = ser_step && !start_i;

  assign feed_step = ser_live || bit_take;
  assign feed_bit  = ser_live ? ser_bit  : bit_i;
  assign feed_last = ser_live ? ser_last : last_i;

  crc_byte_feed #(
    .ORDER (ORDER)
  ) u_feed (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (byte_take),
    .abort_i (start_i),
    .byte_i  (byte_i),
    .last_i  (last_i),
    .step_o  (ser_step),
    .bit_o   (ser_bit),
    .last_o  (ser_last),
    .busy_o  (ser_busy)
  );

  crc_shift_core #(
    .W      (CRC_W),
    .POLY   (POLY),
    .PRESET (PRESET),
    .XOROUT (XOROUT),
    .ORDER  (ORDER)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .step_i  (feed_step),
    .bit_i   (feed_bit),
    .last_i  (feed_last),
    .crc_o   (crc_o),
    .done_o  (done_o),
    .pass_o  (pass_o)
  );

  assign busy_o = ser_busy;

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> !busy_o);

endmodule

// File: tb/crc_serial_unit_tb.sv
`timescale 1ns/1ps
module crc_serial_unit_tb;
  import crc_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_d = 1'b0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_d = '0;
  logic       last = 1'b0;

  logic [7:0] a_crc, b_crc;
  logic       a_busy, a_done, a_pass, b_busy, b_done, b_pass;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic fb [0:63];
  int   flen;

  always #2.5 clk = ~clk;

  crc_serial_unit #(.CRC_W(8), .POLY(8'h07), .PRESET(8'h00), .XOROUT(8'h00),
                    .ORDER(ORDER_MSB)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bit_valid_i(bit_valid), .bit_i(bit_d),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .last_i(last), .busy_o(a_busy),
    .crc_o(a_crc), .done_o(a_done), .pass_o(a_pass));

  crc_serial_unit #(.CRC_W(8), .POLY(8'h07), .PRESET(8'hFF), .XOROUT(8'hFF),
                    .ORDER(ORDER_LSB)) u_dut_lsb (
    .clk(clk), .rst_n(rst_n), .start_i(start), .bit_valid_i(bit_valid), .bit_i(bit_d),
    .byte_valid_i(byte_valid), .byte_i(byte_d), .last_i(last), .busy_o(b_busy),
    .crc_o(b_crc), .done_o(b_done), .pass_o(b_pass));

  // Long division of (P*x^L + M*x^8) by x^8+x^2+x+1.
  function automatic logic [7:0] model_raw(input int len, input logic [7:0] p);
    logic       arr [0:79];
    logic [8:0] g;
    logic [7:0] rem;
    g = 9'h107;
    for (int i = 0; i < 80; i++) arr[i] = (i < len) ? fb[i] : 1'b0;
    for (int j = 0; j < 8; j++) arr[j] = arr[j] ^ p[7-j];
    for (int i = 0; i < len; i++)
      if (arr[i]) for (int k = 0; k <= 8; k++) arr[i+k] = arr[i+k] ^ g[8-k];
    for (int t = 0; t < 8; t++) rem[7-t] = arr[len+t];
    return rem;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = v[7-i];
    return m;
  endfunction

  task automatic clear_frame();
    flen = 0;
  endtask

  task automatic add_byte(input logic [7:0] b, input bit lsb);
    for (int i = 0; i < 8; i++) begin
      fb[flen] = lsb ? b[i] : b[7-i];
      flen++;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b, input bit is_last);
    @(negedge clk); byte_valid = 1'b1; byte_d = b; last = is_last;
    @(negedge clk); byte_valid = 1'b0; last = 1'b0;
    while (a_busy) @(negedge clk);
  endtask

  task automatic put_bit(input logic b, input bit is_last);
    @(negedge clk); bit_valid = 1'b1; bit_d = b; last = is_last;
    @(negedge clk); bit_valid = 1'b0; last = 1'b0;
  endtask

  // Expected outputs of the two configurations for the frame in fb.
  function automatic logic [7:0] exp_a();
    return model_raw(flen, 8'h00);
  endfunction

  function automatic logic [7:0] exp_b();
    return rev8(model_raw(flen, 8'hFF) ^ 8'hFF);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    finish_run();
  end

  initial begin : main
    logic [7:0] ea, eb, va, vb, cr, res_b;
    logic [7:0] m3 [0:2];
    logic [7:0] fr [0:3];
    int bl;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(a_crc == 8'h00, "R1 crc a", a_crc, 0);
    check(b_crc == 8'h00, "R1 crc b", b_crc, 0);
    check(!a_busy && !a_done, "R1 flags", {a_busy, a_done}, 0);

    // R4 known byte, both orders
    pulse_start();
    put_byte(8'h57, 1'b1);
    check(a_done == 1'b1, "R7 done after byte", a_done, 1);
    check(a_crc == 8'hA2, "R4 0x57 msb", a_crc, 8'hA2);
    clear_frame(); add_byte(8'h57, 1'b1); eb = exp_b();
    check(b_crc == eb, "R4 0x57 lsb", b_crc, eb);

    // R2 R3 sweep of all single bytes
    for (int v = 0; v < 256; v++) begin
      pulse_start();
      put_byte(v[7:0], 1'b1);
      clear_frame(); add_byte(v[7:0], 1'b0); ea = exp_a();
      clear_frame(); add_byte(v[7:0], 1'b1); eb = exp_b();
      check(a_crc == ea, "R2 byte sweep msb", a_crc, ea);
      check(b_crc == eb, "R3 byte sweep lsb", b_crc, eb);
    end

    // R2 multi-byte messages
    for (int n = 2; n <= 4; n++) begin
      pulse_start();
      for (int k = 0; k < n; k++) put_byte(8'(k * 61 + n * 17), k == n - 1);
      clear_frame(); for (int k = 0; k < n; k++) add_byte(8'(k * 61 + n * 17), 1'b0); ea = exp_a();
      clear_frame(); for (int k = 0; k < n; k++) add_byte(8'(k * 61 + n * 17), 1'b1); eb = exp_b();
      check(a_crc == ea, "R2 multi msb", a_crc, ea);
      check(b_crc == eb, "R2 multi lsb", b_crc, eb);
    end

    // R2 R7 R11 bit mode
    for (int len = 1; len <= 12; len++) begin
      pulse_start();
      clear_frame();
      for (int i = 0; i < len; i++) begin
        fb[flen] = ((i * 5 + len) % 3) != 0;
        put_bit(fb[flen], i == len - 1);
        flen++;
        if (i != len - 1) check(a_done == 1'b0, "R7 no early done", a_done, 0);
      end
      check(a_done == 1'b1, "R7 done after bit", a_done, 1);
      ea = exp_a(); eb = exp_b();
      check(a_crc == ea, "R2 bits msb", a_crc, ea);
      check(b_crc == rev8(model_raw(flen, 8'hFF) ^ 8'hFF), "R2 bits lsb", b_crc, eb);
      repeat (3) @(negedge clk);
      check(a_crc == ea && b_crc == eb, "R11 idle hold", a_crc, ea);
    end

    // R5 R6 busy blocks further input
    pulse_start();
    @(negedge clk); byte_valid = 1'b1; byte_d = 8'h3C; last = 1'b1; bit_valid = 1'b1; bit_d = 1'b1;
    @(negedge clk); byte_d = 8'hFF; last = 1'b0;
    bl = 0;
    while (a_busy) begin
      bl++;
      @(negedge clk);
    end
    byte_valid = 1'b0; bit_valid = 1'b0;
    check(bl == 8, "R5 busy length", bl, 8);
    check(a_done == 1'b1, "R7 done at end of byte", a_done, 1);
    clear_frame(); add_byte(8'h3C, 1'b0); ea = exp_a();
    check(a_crc == ea, "R6 ignored while busy", a_crc, ea);
    clear_frame(); add_byte(8'h3C, 1'b1); eb = exp_b();
    check(b_crc == eb, "R5 ignored while busy lsb", b_crc, eb);

    // R10 abort a byte, then start with data
    @(negedge clk); byte_valid = 1'b1; byte_d = 8'hA5;
    @(negedge clk); byte_valid = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(a_busy == 1'b0, "R10 abort busy", a_busy, 0);
    check(a_crc == 8'h00 && b_crc == 8'h00, "R10 abort preset", a_crc, 0);
    @(negedge clk); start = 1'b1; bit_valid = 1'b1; bit_d = 1'b1; last = 1'b1;
    @(negedge clk); start = 1'b0; bit_valid = 1'b0; last = 1'b0;
    clear_frame(); fb[0] = 1'b1; flen = 1; ea = exp_a(); eb = exp_b();
    check(a_crc == ea, "R10 start with bit msb", a_crc, ea);
    check(b_crc == eb, "R10 start with bit lsb", b_crc, eb);

    // R8 one-pass residue, R9 single-bit flips
    m3[0] = 8'h12; m3[1] = 8'h9E; m3[2] = 8'h40;
    clear_frame(); add_byte(8'hFF, 1'b0); res_b = rev8(model_raw(8, 8'h00) ^ 8'hFF);
    for (int d = 0; d < 2; d++) begin
      pulse_start();
      for (int k = 0; k < 3; k++) put_byte(m3[k], 1'b0);
      cr = (d == 0) ? a_crc : b_crc;
      for (int k = 0; k < 3; k++) fr[k] = m3[k];
      fr[3] = cr;
      put_byte(cr, 1'b1);
      va = (d == 0) ? {7'd0, a_pass} : {7'd0, b_pass};
      vb = (d == 0) ? a_crc : b_crc;
      check(va == 8'd1, "R8 one-pass pass", va, 1);
      check(vb == ((d == 0) ? 8'h00 : res_b), "R8 residue value", vb, (d == 0) ? 0 : res_b);
      for (int p = 0; p < 32; p++) begin
        pulse_start();
        for (int k = 0; k < 4; k++)
          put_byte((k == p / 8) ? (fr[k] ^ (8'h01 << (p % 8))) : fr[k], k == 3);
        va = (d == 0) ? {7'd0, a_pass} : {7'd0, b_pass};
        check(va == 8'd0, "R9 flipped bit rejected", va, 0);
      end
    end

    finish_run();
  end

endmodule